// File: doc/BRIEF.md
# Reloadable Interval Down-Counter

This block is a 16-bit down-counter paired with a 16-bit holding latch. Software reaches both through a byte-wide port with four addresses. The counter steps down by one on each cycle in which the tick enable is high. The sweep runs through zero into the all-ones value. At that point a one-cycle interrupt pulse goes to an external flag register.

In continuous mode the counter refills from the latch on the tick after it reaches all-ones, so successive pulses are latch + 2 ticks apart.

In one-shot mode only the first zero crossing after a start produces a pulse. The counter then keeps counting downward without refilling.

A start is a write of the counter high byte. It completes the latch and copies the whole latch into the counter. The latch-only addresses never disturb a running count.

Top module: `rtimer_top`

## Requirements
- R1: After reset the latch and the counter both read 0xFFFF and irqPulse is low.
- R2: The regSel encoding is: 0 = counter low byte, 1 = counter high byte, 2 = latch low byte, 3 = latch high byte. rdData is combinational and returns the selected byte of the live counter or the latch.
- R3: A write to address 0 or address 2 replaces only the latch low byte. The counter is unchanged.
- R4: A write to address 1 replaces the latch high byte and, at the same clock edge, loads the completed 16-bit latch into the counter. This load wins over a tick in the same cycle.
- R5: A write to address 3 replaces only the latch high byte. The counter is not reloaded.
- R6: The counter drops by exactly one on each cycle with tickEn high, and holds its value on cycles with tickEn low.
- R7: With contMode high, a tick while the counter is 0xFFFF loads the current latch value instead of decrementing. In steady counting, pulses are therefore latch + 2 ticks apart.
- R8: When enabled, irqPulse is high for exactly one cycle, in the cycle after the tick that moves the counter from 0 to 0xFFFF.
- R9: With contMode low, only the first zero crossing after an address-1 write raises irqPulse. The counter continues to 0xFFFF, 0xFFFE and onward without reloading. A new address-1 write re-arms the pulse.
- R10: With contMode high, every zero crossing raises irqPulse, even when no start has occurred since the last pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Byte write strobe |
| regSel | input | 2 | Register address for both read and write |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Selected register byte (combinational) |
| tickEn | input | 1 | Count enable for this cycle |
| contMode | input | 1 | 1 = continuous refill, 0 = one-shot |
| irqPulse | output | 1 | One-cycle interrupt flag set pulse |

## Verification
The bench measures the spacing between pulses in continuous mode. A design that refills on zero instead of on 0xFFFF would show a gap of latch + 1 instead of latch + 2.

It writes address 1 in the same cycle as a tick. A design that lets the decrement win would read one below the latch.

It runs past the first crossing in one-shot mode and confirms that the counter reads 0xFFFC rather than a refilled value. It also confirms that no second pulse appears before a new start.

It writes the latch-only addresses in the middle of a count. Any accidental reload would then show up as a jump in the counter bytes.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;

  typedef enum logic [1:0] {
    ADDR_CNT_LO = 2'd0,
    ADDR_CNT_HI = 2'd1,
    ADDR_LAT_LO = 2'd2,
    ADDR_LAT_HI = 2'd3
  } regSel_e;

  typedef struct packed {
    logic latchLoWr;
    logic latchHiWr;
    logic startCount;
    logic decrement;
    logic reload;
  } dpStrobe_t;

endpackage

// File: rtl/rtimer_datapath.sv
module rtimer_datapath
  import rtimer_pkg::*;
#(
  parameter int CntW = 16,
  localparam int ByteW = CntW / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [ByteW-1:0] wrData,
  input  regSel_e          rdSel,
  output logic [ByteW-1:0] rdData,
  output logic [CntW-1:0]  counter,
  output logic [CntW-1:0]  latch,
  output logic             isZero,
  output logic             isAllOnes
);

  localparam int NumLanes = 2;

  logic [NumLanes-1:0] laneWr;
  assign laneWr = {strobe.latchHiWr, strobe.latchLoWr};

  // Latch byte lanes
  for (genvar lane = 0; lane < NumLanes; lane++) begin : g_latchLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        latch[lane*ByteW +: ByteW] <= '1;
      end else if (laneWr[lane]) begin
        latch[lane*ByteW +: ByteW] <= wrData;
      end
    end
  end

  // Counter register: start > reload > decrement
  logic [CntW-1:0] counterNext;
  always_comb begin
    counterNext = counter;
    if (strobe.startCount) begin
      counterNext = {wrData, latch[ByteW-1:0]};
    end else if (strobe.reload) begin
      counterNext = latch;
    end else if (strobe.decrement) begin
      counterNext = counter - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter <= '1;
    end else begin
      counter <= counterNext;
    end
  end

  assign isZero    = (counter == '0);
  assign isAllOnes = (counter == '1);

  always_comb begin
    unique case (rdSel)
      ADDR_CNT_LO: rdData = counter[ByteW-1:0];
      ADDR_CNT_HI: rdData = counter[CntW-1:ByteW];
      ADDR_LAT_LO: rdData = latch[ByteW-1:0];
      ADDR_LAT_HI: rdData = latch[CntW-1:ByteW];
      default:     rdData = '0;
    endcase
  end

  AST_START_COPIES_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startCount |=> (counter == latch)); // R4

  AST_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (counter == $past(latch))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.startCount || strobe.reload || strobe.decrement) |=> $stable(counter)); // R6

endmodule

// File: rtl/rtimer_ctrl.sv
module rtimer_ctrl
  import rtimer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  regSel_e   wrSel,
  input  logic      tickEn,
  input  logic      contMode,
  input  logic      isZero,
  input  logic      isAllOnes,
  output dpStrobe_t strobe,
  output logic      irqPulse
);

  logic armed;
  logic startWr;
  logic crossing;
  logic firePulse;

  assign startWr = wrEn && (wrSel == ADDR_CNT_HI);

  always_comb begin
    strobe            = '0;
    strobe.latchLoWr  = wrEn && ((wrSel == ADDR_CNT_LO) || (wrSel == ADDR_LAT_LO));
    strobe.latchHiWr  = wrEn && ((wrSel == ADDR_CNT_HI) || (wrSel == ADDR_LAT_HI));
    strobe.startCount = startWr;
    strobe.reload     = tickEn && !startWr && contMode && isAllOnes;
    strobe.decrement  = tickEn && !startWr && !(contMode && isAllOnes);
  end

  assign crossing  = tickEn && !startWr && isZero;
  assign firePulse = crossing && (contMode || armed);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= firePulse;
      if (startWr) begin
        armed <= 1'b1;
      end else if (firePulse) begin
        armed <= 1'b0;
      end
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R8

  AST_ONESHOT_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!contMode && !armed) |=> !irqPulse); // R9

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> armed); // R9

endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
  import rtimer_pkg::*;
#(
  parameter int CntW = 16,
  localparam int ByteW = CntW / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       regSel,
  input  logic [ByteW-1:0] wrData,
  output logic [ByteW-1:0] rdData,
  input  logic             tickEn,
  input  logic             contMode,
  output logic             irqPulse
);

  dpStrobe_t       strobe;
  logic [CntW-1:0] counter;
  logic [CntW-1:0] latch;
  logic            isZero;
  logic            isAllOnes;
  regSel_e         sel;

  assign sel = regSel_e'(regSel);

  rtimer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (sel),
    .tickEn    (tickEn),
    .contMode  (contMode),
    .isZero    (isZero),
    .isAllOnes (isAllOnes),
    .strobe    (strobe),
    .irqPulse  (irqPulse)
  );

  rtimer_datapath #(.CntW(CntW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdSel     (sel),
    .rdData    (rdData),
    .counter   (counter),
    .latch     (latch),
    .isZero    (isZero),
    .isAllOnes (isAllOnes)
  );

  AST_PULSE_LEAVES_ALLONES: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (counter == {CntW{1'b1}})); // R8

  AST_LATCH_HI_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sel == ADDR_LAT_HI && !tickEn) |=> $stable(counter)); // R5

  AST_LATCH_LO_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (sel == ADDR_LAT_LO || sel == ADDR_CNT_LO) && !tickEn) |=> $stable(counter)); // R3

endmodule

// File: tb/rtimer_top_tb.sv
module rtimer_top_tb;

  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       tickEn = 1'b0;
  logic       contMode = 1'b0;
  logic       irqPulse;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  int cyc = 0;
  int lastPulse = -1;
  int minGap = 0;
  int maxGap = 0;
  int widthViol = 0;
  logic prevPulse = 1'b0;
  bit finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  rtimer_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .regSel   (regSel),
    .wrData   (wrData),
    .rdData   (rdData),
    .tickEn   (tickEn),
    .contMode (contMode),
    .irqPulse (irqPulse)
  );

  // Pulse monitor, sampled shortly after each rising edge
  always @(posedge clk) begin
    #2;
    cyc++;
    if (irqPulse) begin
      if (prevPulse) widthViol++;
      if (lastPulse >= 0) begin
        if (minGap == 0 || cyc - lastPulse < minGap) minGap = cyc - lastPulse;
        if (cyc - lastPulse > maxGap) maxGap = cyc - lastPulse;
      end
      lastPulse = cyc;
      pulseCnt++;
    end
    prevPulse = irqPulse;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clearStats();
    pulseCnt = 0; lastPulse = -1; minGap = 0; maxGap = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; regSel = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] loAddr, output int val);
    logic [7:0] lo;
    regSel = loAddr; #1; lo = rdData;
    regSel = loAddr + 2'd1; #1;
    val = {rdData, lo};
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic testReset();
    int v;
    rd16(2'd0, v); chk("R1 R2 counter after reset", v, 16'hFFFF);
    rd16(2'd2, v); chk("R1 R2 latch after reset", v, 16'hFFFF);
    chk("R1 pulse low after reset", int'(irqPulse), 0);
  endtask

  task automatic testLatchWrites();
    int v;
    wr(2'd0, 8'h34);
    @(negedge clk); rd16(2'd2, v); chk("R3 addr0 sets latch low", v, 16'hFF34);
    rd16(2'd0, v); chk("R3 addr0 keeps counter", v, 16'hFFFF);
    wr(2'd2, 8'h12);
    @(negedge clk); rd16(2'd2, v); chk("R3 addr2 sets latch low", v, 16'hFF12);
    wr(2'd3, 8'h56);
    @(negedge clk); rd16(2'd2, v); chk("R5 addr3 sets latch high", v, 16'h5612);
    rd16(2'd0, v); chk("R5 addr3 no reload", v, 16'hFFFF);
  endtask

  task automatic testStartAndTick();
    int v;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    @(negedge clk); rd16(2'd0, v); chk("R4 start loads counter", v, 16'h0005);
    rd16(2'd2, v); chk("R4 start completes latch", v, 16'h0005);
    ticks(3);
    rd16(2'd0, v); chk("R6 three ticks", v, 16'h0002);
    repeat (3) @(negedge clk);
    rd16(2'd0, v); chk("R6 hold without tick", v, 16'h0002);
  endtask

  task automatic testStartPriority();
    int v;
    @(negedge clk);
    tickEn = 1'b1; wrEn = 1'b1; regSel = 2'd1; wrData = 8'h01;
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    rd16(2'd0, v); chk("R4 start beats tick", v, 16'h0105);
  endtask

  task automatic testContinuous();
    int v;
    contMode = 1'b1;
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h00);
    clearStats();
    ticks(20);
    chk("R10 pulse count continuous", pulseCnt, 4);
    chk("R7 min gap latch+2", minGap, 5);
    chk("R7 max gap latch+2", maxGap, 5);
    rd16(2'd0, v); chk("R7 counter after reload", v, 16'h0003);
  endtask

  task automatic testOneShot();
    int v;
    contMode = 1'b0;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h00);
    clearStats();
    ticks(6);
    chk("R9 one pulse in one-shot", pulseCnt, 1);
    rd16(2'd0, v); chk("R9 counts past all-ones", v, 16'hFFFC);
    ticks(2);
    chk("R9 no extra pulse", pulseCnt, 1);
    wr(2'd1, 8'h00);
    clearStats();
    ticks(3);
    chk("R9 rearm after start", pulseCnt, 1);
    rd16(2'd0, v); chk("R8 counter all-ones after crossing", v, 16'hFFFF);
  endtask

  task automatic testContUnarmed();
    int v;
    contMode = 1'b1;
    clearStats();
    ticks(4);
    chk("R10 pulse without new start", pulseCnt, 1);
    rd16(2'd0, v); chk("R7 reload then sweep", v, 16'hFFFF);
    wr(2'd2, 8'h07);
    ticks(1);
    rd16(2'd0, v); chk("R7 reload uses new latch", v, 16'h0007);
    ticks(2);
    wr(2'd3, 8'h40);
    @(negedge clk); rd16(2'd0, v); chk("R5 mid-count latch high", v, 16'h0005);
    wr(2'd0, 8'h09);
    @(negedge clk); rd16(2'd0, v); chk("R3 mid-count latch low", v, 16'h0005);
    rd16(2'd2, v); chk("R2 latch readback", v, 16'h4009);
    chk("R8 pulse width one cycle", widthViol, 0);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testLatchWrites();
    testStartAndTick();
    testStartPriority();
    testContinuous();
    testOneShot();
    testContUnarmed();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule